// File: doc/BRIEF.md
# Three-State Switch Probe Sequencer

This block reads a three-position switch (tied high, left open, tied low) through one bidirectional pad. It cannot tell an open switch from a plain sample, so it probes. It drives the pad to 1 for a charge interval and then releases the pad. After a settle interval it samples the pad. It then does the same with the pad driven to 0. A closed switch forces the pad to its own level both times. An open switch leaves the external RC node holding whatever level was last driven. The two samples together give the switch position.

The charge, settle and idle-gap lengths are clock-cycle counts taken from input ports. The charge and settle intervals should be set to about one to two microseconds. That is long against the closed-switch RC time and short against leakage discharge of the node. A sequence starts on a start strobe, or repeats by itself while free-run is enabled. The raw pad input passes through a synchronizer before it is sampled. An optional variant changes the reported position only after two identical classifications in a row.

Top module: `tristate_probe_seq`

## Requirements
- R1: After reset the pad is released (`pad_oe_o`=0), `pos_o` is 2'b00 (hold), `invalid_o` is 0 and `done_o` is 0.
- R2: A sequence first drives the pad (`pad_oe_o`=1, `pad_out_o`=1) for exactly C cycles. It then releases the pad for S cycles and takes the first sample (A) from the synchronized input at the end of that release.
- R3: The second phase drives the pad with `pad_out_o`=0 for exactly C cycles. It then releases the pad for S cycles and takes sample B. The pad stays released from then on until a new sequence begins.
- R4: The sample pair A,B is decoded as follows: 1,1 gives up (`pos_o`=2'b01), 0,0 gives down (`pos_o`=2'b10), and 1,0 gives hold (`pos_o`=2'b00). A valid pair clears `invalid_o`.
- R5: The pair A=0,B=1 sets `invalid_o` and leaves `pos_o` at its previous value.
- R6: `done_o` is a one-cycle pulse. It rises 2C+2S clock edges after the edge that accepted the start. `pos_o` and `invalid_o` change only in a cycle where `done_o` is high.
- R7: A charge, settle or gap count of 0 acts as 1 cycle.
- R8: A start strobe that arrives while a sequence is running has no effect.
- R9: With free-run enabled, a new sequence begins after a gap of G idle cycles, so the next `done_o` comes G+2C+2S edges after the previous one. If free-run is cleared during the gap, the block goes idle and the pad stays released.
- R10: With the filter variant selected (FILTER_EN=1), `pos_o` takes a new value only when the current and the previous classification are identical and both valid. An invalid pair breaks the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one probe sequence (ignored while busy) |
| run_free_i | input | 1 | Repeat sequences with an idle gap |
| charge_cyc_i | input | CNT_W | Drive interval length C in cycles |
| settle_cyc_i | input | CNT_W | Release interval length S in cycles |
| gap_cyc_i | input | CNT_W | Free-run idle gap G in cycles |
| pad_in_i | input | 1 | Asynchronous pad input level |
| pad_oe_o | output | 1 | Pad output enable |
| pad_out_o | output | 1 | Pad drive value |
| pos_o | output | 2 | Position: 01 up, 10 down, 00 hold |
| invalid_o | output | 1 | Last sample pair was 0,1 |
| done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
Assertions check several properties on every cycle. The done pulse lasts one cycle, the pad is released whenever done is high, and the drive level stays constant through a charge interval. The result outputs hold steady between done pulses, an impossible sample pair leaves the position untouched, and the interval counter steps down by one. The bench's scenarios cover what the assertions cannot see. These are the exact drive and release lengths, the start-to-done latency for random counts including zero, the decode of each switch state against a modelled RC node, the ignoring of a start while busy, the free-run period and the two-in-a-row filter.

// File: rtl/probe_pkg.sv
package probe_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_DRV_HI, PH_REL_HI, PH_DRV_LO, PH_REL_LO, PH_GAP
   } phase_e;

   localparam logic [1:0] POS_HOLD = 2'b00;
   localparam logic [1:0] POS_UP   = 2'b01;
   localparam logic [1:0] POS_DOWN = 2'b10;
endpackage

// File: rtl/probe_sync.sv
module probe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("probe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else if (i == 0) chain[i] <= d_i;
         else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/probe_timer.sv
module probe_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] count_i,
   output logic         expired_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (load_i) cnt <= (count_i == '0) ? '0 : count_i - 1'b1;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign expired_o = (cnt == '0);

   p_steps_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/probe_classify.sv
module probe_classify
   import probe_pkg::*;
#(
   parameter bit FILTER_EN = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       commit_i,
   input  logic       samp_a_i,
   input  logic       samp_b_i,
   output logic [1:0] pos_o,
   output logic       invalid_o
);
   logic [1:0] cls;
   logic       bad;

   always_comb begin
      bad = 1'b0;
      unique case ({samp_a_i, samp_b_i})
         2'b11:   cls = POS_UP;
         2'b00:   cls = POS_DOWN;
         2'b10:   cls = POS_HOLD;
         default: begin cls = POS_HOLD; bad = 1'b1; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) invalid_o <= 1'b0;
      else if (commit_i) invalid_o <= bad;
   end

   if (FILTER_EN) begin : g_filter
      logic [1:0] prev_cls;
      logic       prev_ok;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_cls <= POS_HOLD;
            prev_ok  <= 1'b0;
            pos_o    <= POS_HOLD;
         end else if (commit_i) begin
            prev_cls <= cls;
            prev_ok  <= !bad;
            if (!bad && prev_ok && prev_cls == cls) pos_o <= cls;
         end
      end
      p_filter_needs_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (commit_i && !prev_ok) |=> $stable(pos_o));
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pos_o <= POS_HOLD;
         else if (commit_i && !bad) pos_o <= cls;
      end
   end

   p_bad_pair_keeps_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !samp_a_i && samp_b_i) |=> (invalid_o && $stable(pos_o)));
endmodule

// File: rtl/tristate_probe_seq.sv
module tristate_probe_seq
   import probe_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             run_free_i,
   input  logic [CNT_W-1:0] charge_cyc_i,
   input  logic [CNT_W-1:0] settle_cyc_i,
   input  logic [CNT_W-1:0] gap_cyc_i,
   input  logic             pad_in_i,
   output logic             pad_oe_o,
   output logic             pad_out_o,
   output logic [1:0]       pos_o,
   output logic             invalid_o,
   output logic             done_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tristate_probe_seq: CNT_W out of range");
   end

   phase_e           phase, phase_nx;
   logic             tmr_load, tmr_exp, take_a, commit, pad_sync, samp_a;
   logic [CNT_W-1:0] tmr_val;

   probe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pad_in_i), .q_o(pad_sync));

   probe_timer #(.W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .count_i(tmr_val),
      .expired_o(tmr_exp));

   always_comb begin
      phase_nx = phase;
      tmr_load = 1'b0;
      tmr_val  = charge_cyc_i;
      take_a   = 1'b0;
      commit   = 1'b0;
      unique case (phase)
         PH_IDLE: if (start_i || run_free_i) begin
            phase_nx = PH_DRV_HI; tmr_load = 1'b1;
         end
         PH_DRV_HI: if (tmr_exp) begin
            phase_nx = PH_REL_HI; tmr_load = 1'b1; tmr_val = settle_cyc_i;
         end
         PH_REL_HI: if (tmr_exp) begin
            phase_nx = PH_DRV_LO; tmr_load = 1'b1; take_a = 1'b1;
         end
         PH_DRV_LO: if (tmr_exp) begin
            phase_nx = PH_REL_LO; tmr_load = 1'b1; tmr_val = settle_cyc_i;
         end
         PH_REL_LO: if (tmr_exp) begin
            commit = 1'b1;
            if (run_free_i) begin
               phase_nx = PH_GAP; tmr_load = 1'b1; tmr_val = gap_cyc_i;
            end else phase_nx = PH_IDLE;
         end
         PH_GAP: if (tmr_exp) begin
            if (run_free_i) begin
               phase_nx = PH_DRV_HI; tmr_load = 1'b1;
            end else phase_nx = PH_IDLE;
         end
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         samp_a <= 1'b0;
         done_o <= 1'b0;
      end else begin
         phase  <= phase_nx;
         done_o <= commit;
         if (take_a) samp_a <= pad_sync;
      end
   end

   assign pad_oe_o  = (phase == PH_DRV_HI) || (phase == PH_DRV_LO);
   assign pad_out_o = (phase == PH_DRV_HI);

   probe_classify #(.FILTER_EN(FILTER_EN)) u_cls (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .samp_a_i(samp_a),
      .samp_b_i(pad_sync), .pos_o(pos_o), .invalid_o(invalid_o));

   p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_result_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(pos_o) && $stable(invalid_o)));
   p_released_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !pad_oe_o);
   p_level_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe_o && $past(pad_oe_o)) |-> $stable(pad_out_o));
endmodule

// File: tb/tb_tristate_probe_seq.sv
module tb_tristate_probe_seq;
   localparam int CLK_PERIOD = 10;
   localparam int SW_HIGH = 0, SW_LOW = 1, SW_OPEN = 2, SW_FAULT = 3;

   logic clk = 0, rst_n = 0, start = 0, run_free = 0;
   logic [7:0] chg = 8'd2, stl = 8'd3, gap = 8'd2;
   logic pad_in, oe, pout, done, inv, done_f, inv_f, oe_f, pout_f, held = 0;
   logic [1:0] pos, pos_f;
   int sw = SW_HIGH;
   int n_chk = 0, n_bad = 0;
   logic [1:0] e_pos = 2'b00, e_pos_f = 2'b00, f_prev = 2'b00;
   logic e_inv = 0, f_ok = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tristate_probe_seq #(.CNT_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .run_free_i(run_free),
      .charge_cyc_i(chg), .settle_cyc_i(stl), .gap_cyc_i(gap), .pad_in_i(pad_in),
      .pad_oe_o(oe), .pad_out_o(pout), .pos_o(pos), .invalid_o(inv), .done_o(done));

   tristate_probe_seq #(.CNT_W(8), .FILTER_EN(1'b1)) dut_f (
      .clk(clk), .rst_n(rst_n), .start_i(start), .run_free_i(run_free),
      .charge_cyc_i(chg), .settle_cyc_i(stl), .gap_cyc_i(gap), .pad_in_i(pad_in),
      .pad_oe_o(oe_f), .pad_out_o(pout_f), .pos_o(pos_f), .invalid_o(inv_f),
      .done_o(done_f));

   // RC node model: closed switch wins, open node keeps last driven level,
   // faulty node flips to the opposite of the last driven level.
   always @(posedge clk) if (oe) held <= pout;
   assign pad_in = (sw == SW_HIGH) ? 1'b1 : (sw == SW_LOW) ? 1'b0 :
                   (sw == SW_OPEN) ? (oe ? pout : held) : (oe ? pout : ~held);

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic logic [1:0] pair_of(int m);
      case (m)
         SW_HIGH: return 2'b11;
         SW_LOW:  return 2'b00;
         SW_OPEN: return 2'b10;
         default: return 2'b01;
      endcase
   endfunction

   task automatic predict(int m);
      logic [1:0] p = pair_of(m);
      logic [1:0] c;
      logic bad = (p == 2'b01);
      c = (p == 2'b11) ? 2'b01 : (p == 2'b00) ? 2'b10 : 2'b00;
      e_inv = bad;
      if (!bad) e_pos = c;
      if (!bad && f_ok && f_prev == c) e_pos_f = c;
      f_prev = c;
      f_ok = !bad;
   endtask

   task automatic run_seq(int m, int c, int s, bit extra_start);
      int n = 1, hi = 0, lo = 0, lat;
      logic [1:0] p0;
      @(negedge clk);
      sw = m; chg = 8'(c); stl = 8'(s); start = 1;
      p0 = pos;
      @(negedge clk);
      start = 0;
      if (oe) begin if (pout) hi++; else lo++; end
      while (!done && n < 1000) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (extra_start && n == 3) start = 1; else start = 0;
         if (oe) begin if (pout) hi++; else lo++; end
         if (!done) check("R6 pos steady before done", int'(pos), int'(p0));
      end
      start = 0;
      lat = 1 + 2*eff(c) + 2*eff(s);
      check(extra_start ? "R8 latency with busy start" : "R6 latency", n, lat);
      check("R2 high drive cycles", hi, eff(c));
      check("R3 low drive cycles", lo, eff(c));
      predict(m);
      check("R4 position", int'(pos), int'(e_pos));
      check("R5 invalid flag", int'(inv), int'(e_inv));
      check("R10 filtered position", int'(pos_f), int'(e_pos_f));
      @(negedge clk);
      check("R6 done one cycle", int'(done), 0);
      check("R3 pad released after", int'(oe), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 oe at reset", int'(oe), 0);
      check("R1 pos at reset", int'(pos), 0);
      check("R1 invalid at reset", int'(inv), 0);
      check("R1 done at reset", int'(done), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // directed corners
      run_seq(SW_HIGH, 0, 0, 0);             // R7 zero counts act as one
      run_seq(SW_LOW, 1, 3, 0);              // R4 down
      run_seq(SW_OPEN, 3, 4, 0);             // R4 hold
      run_seq(SW_FAULT, 2, 3, 0);            // R5 invalid keeps pos
      run_seq(SW_FAULT, 2, 3, 0);
      run_seq(SW_HIGH, 2, 3, 0);             // R5 valid pair clears invalid
      run_seq(SW_HIGH, 2, 3, 0);             // R10 second identical -> filtered updates
      run_seq(SW_LOW, 4, 5, 1);              // R8 start while busy

      for (int i = 0; i < 40; i++)
         run_seq($urandom_range(3, 0), $urandom_range(5, 0), $urandom_range(7, 3), 0);

      // R9 free-run period and stop
      begin
         int m = 0;
         @(negedge clk);
         sw = SW_OPEN; chg = 8'd2; stl = 8'd3; gap = 8'd4; run_free = 1;
         while (!done && m < 1000) begin @(posedge clk); m++; @(negedge clk); end
         m = 0;
         @(posedge clk); m++; @(negedge clk);
         while (!done && m < 1000) begin @(posedge clk); m++; @(negedge clk); end
         check("R9 free-run period", m, 4 + 4 + 6);
         run_free = 0;
         m = 0;
         for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (done || oe) m++;
         end
         check("R9 idle after free-run cleared", m, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule